// File: doc/BRIEF.md
# Double-Buffered Quad DAC Code Register Bank

This block stores the digital codes for four 10-bit digital-to-analog converter channels. Every channel has two stages: a staging register that a serial front end writes through per-channel strobes, and a live register whose value drives the converter. A value written to the staging register reaches the live register only when a transfer event occurs. A per-channel flag marks staging data that has not yet been transferred.

A transfer event comes from one of two sources. The first is a falling edge on an active-low strobe pin, which is enabled by a configuration bit. The pin is synchronised and edge-detected inside the block. The second is a single-cycle software transfer pulse. A transfer moves only those channels that hold untransferred data. When the pin is disabled, a channel write goes directly to the live register. After reset every live code is zero and stays zero until a write and a transfer have taken place.

Top module: `quad_dac_regbank`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every live code (`dac_code`, channel i in bits [10*i+9:10*i]) is 0 and every `pending` bit is 0.
- R2: With `pin_en`=1, a write strobe `wr_en[i]` with no transfer in the same cycle stores `wr_data` in staging for channel i. The live code of channel i is unchanged and `pending[i]` reads 1 after that clock edge.
- R3: With `pin_en`=1, a high-to-low transition of the active-low pin `load_n` transfers every pending channel. The live codes change at the second rising edge after the first edge that samples the pin low.
- R4: A pin held at a steady level, or a low-to-high transition on it, causes no transfer. A pin held low for many cycles transfers only once.
- R5: With `pin_en`=0, a falling edge on `load_n` causes no transfer, and pending channels keep their live codes and their `pending` bits.
- R6: With `pin_en`=0, a write strobe on channel i places `wr_data` on that channel's live code at the same clock edge, and `pending[i]` is 0 afterwards.
- R7: A one-cycle `sw_load`=1 transfers every pending channel at that clock edge, for either value of `pin_en`, and clears their `pending` bits.
- R8: A transfer leaves channels whose `pending` bit is 0 unchanged. Channels are independent, and several strobe bits set together write the same `wr_data` into each selected channel.
- R9: A write and a transfer in the same cycle put the newly written value on the live code, and `pending` for that channel is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 4 | Per-channel write strobes, bit i selects channel i |
| wr_data | input | 10 | Code written to every strobed channel |
| load_n | input | 1 | Asynchronous transfer pin, active low, acts on its falling edge |
| pin_en | input | 1 | 1: the pin controls transfers; 0: writes go direct to the live codes |
| sw_load | input | 1 | Software transfer pulse, one cycle |
| dac_code | output | 40 | Live codes, channel i in bits [10*i+9:10*i] |
| pending | output | 4 | Bit i set while channel i holds untransferred data |

## Verification
The bench targets the two-register latency of the pin synchroniser. A design that counts one register too many or too few moves the live codes a cycle early or late. The bench also holds the pin low for long stretches: a level-sensitive design would transfer again on every later write. It checks a write that coincides with a transfer, where a design that reads the old staging value would put stale data on the output. It also checks that a disabled pin must not touch pending channels, and that a write with the pin disabled must bypass staging. A design that gates wrongly here would leave outputs stuck or transfer data early.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;
    localparam int unsigned NUM_CH_DEF  = 4;
    localparam int unsigned CODE_W_DEF  = 10;
    localparam int unsigned SYNC_N_DEF  = 2;

    // control bundle driven to each channel slice
    typedef struct packed {
        logic wr;      // strobe for this channel
        logic xfer;    // transfer event this cycle
        logic direct;  // pin disabled: write goes straight through
    } ch_ctrl_t;

    function automatic ch_ctrl_t make_ctrl(input logic wr, input logic xfer,
                                           input logic pin_en);
        ch_ctrl_t c;
        c.wr     = wr;
        c.xfer   = xfer;
        c.direct = ~pin_en;
        return c;
    endfunction
endpackage

// File: rtl/load_pin_edge.sv
module load_pin_edge #(
    parameter int unsigned SYNC_N = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fall
);
    localparam int unsigned HIST_W = SYNC_N + 1;

    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '1;
        end else begin
            hist_q <= {hist_q[HIST_W-2:0], pin_n};
        end
    end

    // newest synchronised sample low, previous one high
    assign fall = ~hist_q[SYNC_N-1] & hist_q[SYNC_N];
endmodule

// File: rtl/dac_code_slice.sv
module dac_code_slice
    import dacbank_pkg::*;
#(
    parameter int unsigned CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_ctrl_t          ctrl,
    input  logic [CODE_W-1:0] wdata,
    output logic [CODE_W-1:0] live,
    output logic              pend
);
    logic [CODE_W-1:0] stage_q, live_q, stage_nxt;
    logic              pend_q;

    assign stage_nxt = ctrl.wr ? wdata : stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
            live_q  <= '0;
            pend_q  <= 1'b0;
        end else begin
            stage_q <= stage_nxt;
            if (ctrl.wr && ctrl.direct) begin
                live_q <= wdata;
                pend_q <= 1'b0;
            end else if (ctrl.xfer && (pend_q || ctrl.wr)) begin
                live_q <= stage_nxt;
                pend_q <= 1'b0;
            end else if (ctrl.wr) begin
                pend_q <= 1'b1;
            end
        end
    end

    assign live = live_q;
    assign pend = pend_q;
endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
    import dacbank_pkg::*;
#(
    parameter int unsigned NUM_CH = NUM_CH_DEF,
    parameter int unsigned CODE_W = CODE_W_DEF,
    parameter int unsigned SYNC_N = SYNC_N_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        wr_en,
    input  logic [CODE_W-1:0]        wr_data,
    input  logic                     load_n,
    input  logic                     pin_en,
    input  logic                     sw_load,
    output logic [NUM_CH*CODE_W-1:0] dac_code,
    output logic [NUM_CH-1:0]        pending
);
    logic pin_fall;
    logic xfer;

    load_pin_edge #(.SYNC_N(SYNC_N)) u_edge (
        .clk   (clk),
        .rst   (rst),
        .pin_n (load_n),
        .fall  (pin_fall)
    );

    assign xfer = (pin_en & pin_fall) | sw_load;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        ch_ctrl_t ctl;
        assign ctl = make_ctrl(wr_en[i], xfer, pin_en);

        dac_code_slice #(.CODE_W(CODE_W)) u_slice (
            .clk   (clk),
            .rst   (rst),
            .ctrl  (ctl),
            .wdata (wr_data),
            .live  (dac_code[i*CODE_W +: CODE_W]),
            .pend  (pending[i])
        );
    end
endmodule

// File: rtl/quad_dac_regbank_chk.sv
module quad_dac_regbank_chk #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CODE_W = 10
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CH-1:0]        wr_en,
    input logic [CODE_W-1:0]        wr_data,
    input logic                     pin_en,
    input logic                     sw_load,
    input logic                     pin_fall,
    input logic [NUM_CH*CODE_W-1:0] dac_code,
    input logic [NUM_CH-1:0]        pending
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && pending == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_p
        a_r2_pending_set: assert property (@(posedge clk) disable iff (rst)
            (pin_en && wr_en[i] && !sw_load && !pin_fall) |=> pending[i]);

        a_r7_sw_clears: assert property (@(posedge clk) disable iff (rst)
            (sw_load && !wr_en[i]) |=> !pending[i]);

        a_r6_direct_write: assert property (@(posedge clk) disable iff (rst)
            (!pin_en && wr_en[i]) |=>
                (dac_code[i*CODE_W +: CODE_W] == $past(wr_data) && !pending[i]));

        a_r5_hold_no_event: assert property (@(posedge clk) disable iff (rst)
            (!sw_load && !(pin_en && pin_fall) && !(!pin_en && wr_en[i])) |=>
                $stable(dac_code[i*CODE_W +: CODE_W]));

        a_r8_idle_untouched: assert property (@(posedge clk) disable iff (rst)
            (!pending[i] && !wr_en[i]) |=> $stable(dac_code[i*CODE_W +: CODE_W]));
    end
endmodule

bind quad_dac_regbank quad_dac_regbank_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .pin_en   (pin_en),
    .sw_load  (sw_load),
    .pin_fall (pin_fall),
    .dac_code (dac_code),
    .pending  (pending)
);

// File: tb/quad_dac_regbank_tb.sv
`timescale 1ns/1ps
module quad_dac_regbank_tb;
    localparam int NCH = 4;
    localparam int CW  = 10;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NCH-1:0]     wr_en = '0;
    logic [CW-1:0]      wr_data = '0;
    logic               load_n = 1'b1;
    logic               pin_en = 1'b1;
    logic               sw_load = 1'b0;
    logic [NCH*CW-1:0]  dac_code;
    logic [NCH-1:0]     pending;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference state
    logic [CW-1:0] m_stage [NCH];
    logic [CW-1:0] m_live  [NCH];
    logic [NCH-1:0] m_pend;
    logic h1, h2, h3;

    always #2.5 clk = ~clk;

    quad_dac_regbank u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .load_n(load_n), .pin_en(pin_en), .sw_load(sw_load),
        .dac_code(dac_code), .pending(pending)
    );

    function automatic logic [NCH*CW-1:0] pack_live();
        logic [NCH*CW-1:0] v;
        for (int i = 0; i < NCH; i++) v[i*CW +: CW] = m_live[i];
        return v;
    endfunction

    // one clock edge of the expected behaviour (R1..R9)
    task automatic model_edge();
        logic fall, xfer;
        logic [CW-1:0] nxt;
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin m_stage[i] = '0; m_live[i] = '0; end
            m_pend = '0;
            h1 = 1; h2 = 1; h3 = 1;
        end else begin
            // pin sampled low two edges ago, high three edges ago
            fall = pin_en && !h2 && h3;
            xfer = fall || sw_load;
            for (int i = 0; i < NCH; i++) begin
                nxt = wr_en[i] ? wr_data : m_stage[i];
                if (wr_en[i] && !pin_en) begin
                    m_live[i] = wr_data; m_pend[i] = 0;
                end else if (xfer && (m_pend[i] || wr_en[i])) begin
                    m_live[i] = nxt; m_pend[i] = 0;
                end else if (wr_en[i]) begin
                    m_pend[i] = 1;
                end
                m_stage[i] = nxt;
            end
            h3 = h2; h2 = h1; h1 = load_n;
        end
    endtask

    task automatic check(input string tag);
        vectors++;
        if (dac_code !== pack_live()) begin
            errors++;
            $display("FAIL %s dac_code actual=%h expected=%h", tag, dac_code, pack_live());
        end
        vectors++;
        if (pending !== m_pend) begin
            errors++;
            $display("FAIL %s pending actual=%b expected=%b", tag, pending, m_pend);
        end
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle();
        wr_en = '0; sw_load = 0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        // R1 reset
        tick("R1"); tick("R1");
        rst = 0;
        tick("R1");
        // R2 buffered write
        wr_en = 4'b0001; wr_data = 10'h155; tick("R2");
        idle(); tick("R2"); tick("R2");
        // R3 pin falling edge with latency
        load_n = 0; tick("R3"); tick("R3"); tick("R3"); tick("R3");
        // R4 pin stays low: new write not transferred; release high no transfer
        wr_en = 4'b0010; wr_data = 10'h2AA; tick("R4");
        idle(); for (int k = 0; k < 4; k++) tick("R4");
        load_n = 1; for (int k = 0; k < 4; k++) tick("R4");
        // R7 software transfer, R8 others untouched
        wr_en = 4'b0100; wr_data = 10'h3FF; tick("R8");
        idle(); sw_load = 1; tick("R7");
        sw_load = 0; tick("R7");
        wr_en = 4'b1000; wr_data = 10'h0AB; tick("R8");
        idle(); sw_load = 1; tick("R8");
        sw_load = 0; tick("R8");
        // R9 write coinciding with transfer
        wr_en = 4'b0001; wr_data = 10'h001; sw_load = 1; tick("R9");
        idle(); tick("R9");
        // R5 pin disabled ignores falling edge
        wr_en = 4'b0010; wr_data = 10'h123; tick("R5");
        idle(); pin_en = 0; tick("R5");
        load_n = 0; for (int k = 0; k < 5; k++) tick("R5");
        load_n = 1; tick("R5");
        sw_load = 1; tick("R7");
        sw_load = 0; tick("R7");
        // R6 direct write with pin disabled, multiple strobes (R8)
        wr_en = 4'b0101; wr_data = 10'h0F0; tick("R6");
        idle(); tick("R6");
        pin_en = 1; tick("R6");
        // random mix
        for (int n = 0; n < 4000; n++) begin
            wr_en   = (($urandom % 3) == 0) ? NCH'($urandom) : '0;
            wr_data = CW'($urandom);
            sw_load = (($urandom % 11) == 0);
            if (($urandom % 4) == 0) load_n = ~load_n;
            if (($urandom % 50) == 0) pin_en = ~pin_en;
            tick("R3/R6/R7/R9 random");
        end
        idle(); rst = 1; tick("R1"); rst = 0; tick("R1");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule